// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns a single multi-register memory transfer request into a stream of per-register beats. A request carries a base address, a 16-bit register selection mask, one of four addressing modes, a load/store flag and a write-back enable. After the request is accepted, the block emits one beat for each selected register. A beat holds a memory address, the index of the register that goes with it, and the load/store flag. When the last beat has been accepted, the block raises a one-cycle completion pulse. In that same cycle it shows the base value that the caller should write back.

The four modes differ in two ways: the direction of address movement (upward or downward) and the moment of the step (before or after each access). Mode encoding is 2'b00 increment-after, 2'b01 increment-before, 2'b10 decrement-after, 2'b11 decrement-before. Bit 1 selects a downward direction and bit 0 selects stepping before the access.

The lowest-numbered selected register always lands at the lowest address of the touched range. For this reason, upward modes serve registers in ascending index order and downward modes serve them in descending index order.

The beat output is a valid/ready stream:
- A beat is transferred in a cycle where `beat_valid` and `beat_ready` are both high.
- While `beat_valid` is high and `beat_ready` is low, the beat stays frozen and the sequence does not advance.
- `beat_valid` never depends on `beat_ready`.

Requests are plain control: `req_start` is honoured only while `busy` is low. The address step is the parameter `STEP`, in address units. It defaults to 4 for word memory.

Top module: `blk_xfer_agen`

## Requirements
- R1: In mode 2'b00 (increment-after), the first beat is at the base and each later beat is STEP higher. With STEP 1, base 6 and three registers, the addresses are 6, 7, 8.
- R2: In mode 2'b01 (increment-before), the first beat is at base+STEP and each later beat is STEP higher. With STEP 1, base 6 and three registers, the addresses are 7, 8, 9.
- R3: In mode 2'b10 (decrement-after), the first beat is at the base and each later beat is STEP lower. With STEP 1, base 6 and three registers, the addresses are 6, 5, 4.
- R4: In mode 2'b11 (decrement-before), the first beat is at base-STEP and each later beat is STEP lower. With STEP 1, base 6 and three registers, the addresses are 5, 4, 3.
- R5: Exactly one beat is emitted per set mask bit, and `beat_reg` is the bit position. Upward modes serve registers in ascending order and downward modes in descending order, so the lowest register always gets the lowest address.
- R6: In the `done` cycle with write-back enabled, `wb_base` equals base ± STEP × popcount(mask) (plus for upward modes, minus for downward modes, modulo 2^32) and `wb_we` is high. With write-back disabled, `wb_base` equals the original base and `wb_we` stays low.
- R7: A start with an all-zero mask produces no beat, and `done` rises in the cycle after the start.
- R8: While `beat_valid` is high and `beat_ready` is low, the address and register of the beat hold steady and no beat is consumed.
- R9: `done` is a single-cycle pulse in the cycle after the last accepted beat, and `beat_valid` is low in that cycle.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle. A `req_start` while busy is ignored.
- R11: During and right after reset, `beat_valid`, `done`, `busy` and `wb_we` are low.
- R12: `beat_load` equals the load/store flag captured at start for every beat of the operation (1 = load, 0 = store).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe, taken while idle |
| req_base | input | 32 | Base address of the transfer |
| req_mask | input | 16 | Register selection, bit i selects register i |
| req_mode | input | 2 | Addressing mode (bit1 down, bit0 step-before) |
| req_load | input | 1 | 1 = load, 0 = store |
| req_wb | input | 1 | Write-back enable |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | A beat is presented |
| beat_addr | output | 32 | Address of the beat |
| beat_reg | output | 4 | Register index of the beat |
| beat_load | output | 1 | Direction of the beat |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_we | output | 1 | Write-back strobe, high only with done |
| wb_base | output | 32 | Updated base, meaningful with done |

## Verification
The assertions check the following on every cycle:
- Beats stay frozen under back-pressure.
- Successive accepted beats move by exactly one step and change register.
- `done` is a lone pulse that never coincides with a beat.
- `wb_we` appears only with `done`.
- An accepted start makes the block busy.

Other properties depend on the whole request and can only be shown by the bench's scenarios: the exact address order of each mode, the register pairing, the write-back arithmetic, the empty-mask shortcut and the ignoring of a start while busy. The bench covers them with worked-example requests, full and sparse masks, wrapping addresses and several ready patterns, all against its queue-based model.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

  typedef enum logic [1:0] {
    XM_INC_AFTER  = 2'b00,
    XM_INC_BEFORE = 2'b01,
    XM_DEC_AFTER  = 2'b10,
    XM_DEC_BEFORE = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } seq_state_e;

  function automatic logic mode_down(input xfer_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_pre(input xfer_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/blkx_popcnt.sv
module blkx_popcnt #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/blkx_pick.sv
module blkx_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  input  logic          from_top,
  output logic [IW-1:0] idx,
  output logic          last
);
  logic [IW-1:0] lo_idx;
  logic [IW-1:0] hi_idx;

  // lowest set bit: scanning downward, the final hit is the lowest
  always_comb begin
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) lo_idx = IW'(i);
    end
  end

  // highest set bit: scanning upward, the final hit is the highest
  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) hi_idx = IW'(i);
    end
  end

  assign idx  = from_top ? hi_idx : lo_idx;
  assign last = ((bits & (bits - N'(1))) == '0);
endmodule

// File: rtl/blkx_addr.sv
module blkx_addr
  import blkx_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 5,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] base,
  input  xfer_mode_e    mode,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] final_base
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] span;

  assign span = AW'(count) * STEP_V;

  always_comb begin
    if (mode_down(mode)) begin
      final_base = base - span;
      first_addr = mode_pre(mode) ? base - STEP_V : base;
    end else begin
      final_base = base + span;
      first_addr = mode_pre(mode) ? base + STEP_V : base;
    end
  end
endmodule

// File: rtl/blk_xfer_agen.sv
module blk_xfer_agen
  import blkx_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int STEP = 4,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_start,
  input  logic [AW-1:0]   req_base,
  input  logic [NREG-1:0] req_mask,
  input  logic [1:0]      req_mode,
  input  logic            req_load,
  input  logic            req_wb,
  input  logic            beat_ready,
  output logic            beat_valid,
  output logic [AW-1:0]   beat_addr,
  output logic [IW-1:0]   beat_reg,
  output logic            beat_load,
  output logic            busy,
  output logic            done,
  output logic            wb_we,
  output logic [AW-1:0]   wb_base
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  seq_state_e      state_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   fin_q;
  logic            down_q;
  logic            load_q;
  logic            wb_q;

  logic [CW-1:0]   req_cnt;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   final_base;
  logic [IW-1:0]   pick_idx;
  logic            pick_last;
  logic            take;
  logic            accept;
  xfer_mode_e      mode_in;

  assign mode_in = xfer_mode_e'(req_mode);

  blkx_popcnt #(.N(NREG), .CW(CW)) u_popcnt (
    .bits  (req_mask),
    .count (req_cnt)
  );

  blkx_addr #(.AW(AW), .CW(CW), .STEP(STEP)) u_addr (
    .base       (req_base),
    .mode       (mode_in),
    .count      (req_cnt),
    .first_addr (first_addr),
    .final_base (final_base)
  );

  blkx_pick #(.N(NREG), .IW(IW)) u_pick (
    .bits     (rem_q),
    .from_top (down_q),
    .idx      (pick_idx),
    .last     (pick_last)
  );

  assign accept = (state_q == SQ_IDLE) && req_start;
  assign take   = (state_q == SQ_RUN) && beat_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      fin_q   <= '0;
      down_q  <= 1'b0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (accept) begin
            rem_q   <= req_mask;
            addr_q  <= first_addr;
            base_q  <= req_base;
            fin_q   <= final_base;
            down_q  <= mode_down(mode_in);
            load_q  <= req_load;
            wb_q    <= req_wb;
            state_q <= (req_mask == '0) ? SQ_FIN : SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (take) begin
            rem_q  <= rem_q & ~(NREG'(1) << pick_idx);
            addr_q <= down_q ? addr_q - STEP_V : addr_q + STEP_V;
            if (pick_last) state_q <= SQ_FIN;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign beat_valid = (state_q == SQ_RUN);
  assign beat_addr  = addr_q;
  assign beat_reg   = pick_idx;
  assign beat_load  = load_q;
  assign busy       = (state_q != SQ_IDLE);
  assign done       = (state_q == SQ_FIN);
  assign wb_we      = done && wb_q;
  assign wb_base    = wb_q ? fin_q : base_q;
endmodule

// File: rtl/blkx_chk.sv
module blkx_chk #(
  parameter int AW   = 32,
  parameter int IW   = 4,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_start,
  input logic          beat_ready,
  input logic          beat_valid,
  input logic [AW-1:0] beat_addr,
  input logic [IW-1:0] beat_reg,
  input logic          busy,
  input logic          done,
  input logic          wb_we
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  // R8: a stalled beat is held unchanged
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_reg));

  // R5: consecutive beats differ by one step in address
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready |=> !beat_valid ||
      (beat_addr == $past(beat_addr) + STEP_V) || (beat_addr == $past(beat_addr) - STEP_V));

  // R5: each accepted beat retires its register
  a_r5_reg_moves: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready |=> !beat_valid || (beat_reg != $past(beat_reg)));

  // R9: completion is a single pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: no beat in the completion cycle
  a_r9_no_beat_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_valid);

  // R6: write-back strobe only with completion
  a_r6_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> done);

  // R10: an accepted start makes the block busy
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    req_start && !busy |=> busy);
endmodule

bind blk_xfer_agen blkx_chk #(.AW(AW), .IW(IW), .STEP(STEP)) u_blkx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_start  (req_start),
  .beat_ready (beat_ready),
  .beat_valid (beat_valid),
  .beat_addr  (beat_addr),
  .beat_reg   (beat_reg),
  .busy       (busy),
  .done       (done),
  .wb_we      (wb_we)
);

// File: tb/blk_xfer_agen_bench.sv
module blk_xfer_agen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int NREG = 16;
  localparam int STEP = 1;

  logic        clk;
  logic        rst_n;
  logic        req_start;
  logic [31:0] req_base;
  logic [15:0] req_mask;
  logic [1:0]  req_mode;
  logic        req_load;
  logic        req_wb;
  logic        beat_ready;
  logic        beat_valid;
  logic [31:0] beat_addr;
  logic [3:0]  beat_reg;
  logic        beat_load;
  logic        busy;
  logic        done;
  logic        wb_we;
  logic [31:0] wb_base;

  int vectors;
  int miscompares;
  bit checking;

  blk_xfer_agen #(.AW(AW), .NREG(NREG), .STEP(STEP)) u_blk_xfer_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .req_base   (req_base),
    .req_mask   (req_mask),
    .req_mode   (req_mode),
    .req_load   (req_load),
    .req_wb     (req_wb),
    .beat_ready (beat_ready),
    .beat_valid (beat_valid),
    .beat_addr  (beat_addr),
    .beat_reg   (beat_reg),
    .beat_load  (beat_load),
    .busy       (busy),
    .done       (done),
    .wb_we      (wb_we),
    .wb_base    (wb_base)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- reference model ----------------
  int          m_phase;   // 0 idle, 1 running, 2 completion
  logic [31:0] q_addr[$];
  int          q_reg[$];
  bit          m_load;
  bit          m_wb;
  bit          m_empty;
  bit          m_stalled;
  int          m_mode;
  logic [31:0] m_wbase;

  task automatic model_load(input int mode, input logic [15:0] mask, input logic [31:0] base);
    int list[$];
    int n;
    logic [31:0] a0;
    q_addr.delete();
    q_reg.delete();
    for (int i = 0; i < 16; i++) if (mask[i]) list.push_back(i);
    n = list.size();
    if (mode >= 2) begin
      a0 = (mode == 3) ? base - 32'(STEP) : base;
      for (int k = 0; k < n; k++) begin
        q_addr.push_back(a0 - 32'(k * STEP));
        q_reg.push_back(list[n - 1 - k]);
      end
    end else begin
      a0 = (mode == 1) ? base + 32'(STEP) : base;
      for (int k = 0; k < n; k++) begin
        q_addr.push_back(a0 + 32'(k * STEP));
        q_reg.push_back(list[k]);
      end
    end
    m_wbase = base;
    if (m_wb) m_wbase = (mode >= 2) ? base - 32'(n * STEP) : base + 32'(n * STEP);
    m_empty = (n == 0);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0;
      m_stalled = 0;
      q_addr.delete();
      q_reg.delete();
    end else begin
      m_stalled = 0;
      case (m_phase)
        0: if (req_start) begin
          m_load = req_load;
          m_wb   = req_wb;
          m_mode = int'(req_mode);
          model_load(int'(req_mode), req_mask, req_base);
          m_phase = m_empty ? 2 : 1;
        end
        1: if (beat_ready) begin
          void'(q_addr.pop_front());
          void'(q_reg.pop_front());
          if (q_addr.size() == 0) m_phase = 2;
        end else m_stalled = 1;
        default: m_phase = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R1 increment-after";
      1: return "R2 increment-before";
      2: return "R3 decrement-after";
      default: return "R4 decrement-before";
    endcase
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      chk({mode_tag(m_mode), " beat_valid"}, 32'(beat_valid), 32'(m_phase == 1));
      if (m_phase == 1) begin
        chk(m_stalled ? "R8 held address" : {mode_tag(m_mode), " address"}, beat_addr, q_addr[0]);
        chk(m_stalled ? "R8 held register" : "R5 register index", 32'(beat_reg), 32'(q_reg[0]));
        chk("R12 beat_load", 32'(beat_load), 32'(m_load));
      end
      chk(m_empty ? "R7 empty done" : "R9 done pulse", 32'(done), 32'(m_phase == 2));
      chk("R10 busy", 32'(busy), 32'(m_phase != 0));
      chk("R6 wb_we", 32'(wb_we), 32'(m_phase == 2 && m_wb));
      if (m_phase == 2) chk("R6 wb_base", wb_base, m_wbase);
    end
  end

  // ---------------- stimulus ----------------
  int cyc;

  task automatic run_op(input int mode, input logic [15:0] mask, input logic [31:0] base,
                        input bit ld, input bit wb, input int rdy_kind, input bit poke);
    int n;
    @(negedge clk);
    req_start = 1'b1;
    req_mode  = 2'(mode);
    req_mask  = mask;
    req_base  = base;
    req_load  = ld;
    req_wb    = wb;
    beat_ready = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    n = 0;
    while (m_phase != 0) begin
      case (rdy_kind)
        0: beat_ready = 1'b1;
        1: beat_ready = n[0];
        2: beat_ready = ($urandom % 3) != 0;
        default: beat_ready = (n >= 3);
      endcase
      // R10: a start while busy must be ignored
      if (poke && n == 1) begin
        req_start = 1'b1;
        req_mask  = 16'hFFFF;
        req_mode  = 2'(3 - mode);
        req_base  = 32'h5555_0000;
      end else req_start = 1'b0;
      n++;
      @(negedge clk);
    end
    req_start = 1'b0;
  endtask

  initial begin
    vectors = 0;
    miscompares = 0;
    checking = 0;
    rst_n = 1'b0;
    req_start = 1'b0;
    req_base = '0;
    req_mask = '0;
    req_mode = '0;
    req_load = 1'b0;
    req_wb = 1'b0;
    beat_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 beat_valid in reset", 32'(beat_valid), 32'd0);
    chk("R11 done in reset", 32'(done), 32'd0);
    chk("R11 busy in reset", 32'(busy), 32'd0);
    chk("R11 wb_we in reset", 32'(wb_we), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 beat_valid after reset", 32'(beat_valid), 32'd0);
    chk("R11 busy after reset", 32'(busy), 32'd0);
    checking = 1;

    // R1..R4: worked examples, registers 1..3 at base 6
    run_op(0, 16'h000E, 32'd6, 1, 1, 0, 0);
    run_op(1, 16'h000E, 32'd6, 1, 1, 0, 0);
    run_op(2, 16'h000E, 32'd6, 0, 1, 0, 0);
    run_op(3, 16'h000E, 32'd6, 0, 1, 0, 0);
    // R5: sparse masks, pairing in every mode
    for (int m = 0; m < 4; m++) run_op(m, 16'h8421, 32'h0000_1000, m[0], 1, 1, 0);
    // R6: write-back disabled
    run_op(1, 16'h00F0, 32'h0000_0100, 1, 0, 0, 0);
    run_op(3, 16'h00F0, 32'h0000_0100, 0, 0, 0, 0);
    // R7: empty mask in both directions
    run_op(0, 16'h0000, 32'h0000_0040, 1, 1, 0, 0);
    run_op(3, 16'h0000, 32'h0000_0040, 0, 1, 0, 0);
    // R8: back-pressure at the start and at random
    run_op(2, 16'h0F0F, 32'h0000_0200, 1, 1, 3, 0);
    for (int m = 0; m < 4; m++) run_op(m, 16'hFFFF, 32'h0000_0008, m[1], 1, 2, 0);
    // R4/R6: address wrap below zero and above the top
    run_op(3, 16'h0007, 32'h0000_0001, 0, 1, 0, 0);
    run_op(1, 16'h0003, 32'hFFFF_FFFF, 1, 1, 0, 0);
    // R10: starts while busy are ignored
    run_op(0, 16'h0330, 32'h0000_0020, 1, 1, 1, 1);
    run_op(3, 16'h0001, 32'h0000_0020, 0, 1, 0, 1);
    // R12: single beat, load then store
    run_op(0, 16'h8000, 32'h0000_0300, 1, 1, 0, 0);
    run_op(0, 16'h8000, 32'h0000_0300, 0, 1, 0, 0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // watchdog
  initial begin
    cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    miscompares++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule